// File: doc/BRIEF.md
# Stream Packet Timing Monitor

This block sits beside a valid/ready packet stream and watches it without driving any of its signals. It measures three things for every packet: how many beats were accepted, how many cycles the source held data that the sink would not take, and how long the stream sat between the end of the previous packet and the start of this one. When a packet ends, the block presents one record of these values, plus a flag that marks the packet as shorter than a configured expected length.

The records show whether a link is paced by its source or by its sink. A healthy stream has few not-ready cycles and gaps that stay steady. Long backpressure runs, or a burst of short packets, point to a sink that throttles too hard or to a source that gave up on a frame. The monitor only produces records. Storing and reading them is left to the logic that consumes the report port.

Top module: `pkt_flow_monitor`

## Requirements
- R1: After reset, `rpt_strobe` is low and all report fields read zero until the first packet ends.
- R2: A packet opens on an accepted beat (valid and ready both high) that has `mon_sop` set while no packet is open. Accepted beats seen while no packet is open, and not carrying an opening `mon_sop`, are ignored: they produce no record and are not counted.
- R3: The reported length is the number of accepted beats from the opening beat through the beat that carries `mon_eop`, both included.
- R4: The reported not-ready count is the number of cycles with valid high and ready low while the packet is open. Such cycles before the opening beat is accepted are not counted.
- R5: The reported gap is the number of cycles from the previous packet's closing beat to this packet's opening beat, so a packet that opens in the cycle right after a close reports 1. The first packet after reset reports all ones in the gap field.
- R6: `rpt_short` is high when the reported length is strictly less than `cfg_expect_len`, sampled in the closing cycle. A length equal to the expected length is not short.
- R7: `rpt_strobe` is high for exactly the one cycle after each closing beat. The report fields change only together with a strobe and hold their value between records.
- R8: The length, not-ready and gap counts saturate at their all-ones value instead of wrapping.
- R9: A single accepted beat with both `mon_sop` and `mon_eop` set is a complete packet of length 1 with a not-ready count of 0.
- R10: A `mon_sop` seen on an accepted beat while a packet is already open is treated as an ordinary data beat. It adds 1 to the length and does not restart the counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_valid | input | 1 | Observed stream valid |
| mon_ready | input | 1 | Observed stream ready |
| mon_sop | input | 1 | Observed start-of-packet marker |
| mon_eop | input | 1 | Observed end-of-packet marker |
| cfg_expect_len | input | LEN_W | Expected packet length in beats for the short flag |
| rpt_strobe | output | 1 | One-cycle record strobe |
| rpt_len | output | LEN_W | Packet length in beats |
| rpt_stall | output | STALL_W | Not-ready cycles inside the packet |
| rpt_gap | output | GAP_W | Cycles since the previous packet closed |
| rpt_short | output | 1 | Length below the expected length |

## Verification
Two cases put a packet's close and the next packet's open next to each other.

- **Close and open in one cycle.** A single-beat packet opens and closes in the same cycle. In that cycle the gap value is latched and the gap timer is reloaded.
- **Back-to-back packets.** A two-beat packet is followed at once by a single-beat packet. The first record's strobe then falls in the same cycle as the second packet's opening beat.

The bench drives this exact sequence. It expects two strobes in consecutive cycles. The first record must carry the gap of the first packet. The second record must carry length 1, a not-ready count of 0 and a gap of 1.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  localparam int PFM_LEN_W_DEF   = 8;
  localparam int PFM_STALL_W_DEF = 8;
  localparam int PFM_GAP_W_DEF   = 10;

  typedef enum logic {
    PS_IDLE = 1'b0,
    PS_OPEN = 1'b1
  } pfm_state_e;

endpackage

// File: rtl/pfm_sat_cnt.sv
module pfm_sat_cnt #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_d  = q;
    q_en = 1'b0;
    if (load) begin
      q_d  = load_val;
      q_en = 1'b1;
    end else if (inc && (q != CNT_MAX)) begin
      q_d  = q + 1'b1;
      q_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (q_en) begin
      q <= q_d;
    end
  end

  // R8: a saturated counter stays saturated until reloaded
  a_r8_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (q == CNT_MAX && !load) |=> (q == CNT_MAX));

  // R8: without load, the value never decreases
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> (q >= $past(q)));

endmodule

// File: rtl/pfm_pkt_tracker.sv
module pfm_pkt_tracker
  import pfm_pkg::*;
#(
  parameter int LEN_W   = PFM_LEN_W_DEF,
  parameter int STALL_W = PFM_STALL_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  logic               ready,
  input  logic               sop,
  input  logic               eop,
  output logic               sop_beat,
  output logic               eop_beat,
  output logic [LEN_W-1:0]   fin_len,
  output logic [STALL_W-1:0] fin_stall
);

  localparam logic [LEN_W-1:0]   LEN_MAX  = '1;
  localparam logic [LEN_W-1:0]   LEN_ONE  = LEN_W'(1);
  localparam logic [STALL_W-1:0] STALL_Z  = '0;

  pfm_state_e         st_q, st_d;
  logic               pkt_open;
  logic               beat;
  logic               pkt_beat;
  logic               stall_cyc;
  logic [LEN_W-1:0]   len_q;
  logic [STALL_W-1:0] stall_q;

  assign pkt_open  = (st_q == PS_OPEN);
  assign beat      = valid & ready;
  assign sop_beat  = beat & sop & ~pkt_open;
  assign pkt_beat  = beat & (pkt_open | sop_beat);
  assign eop_beat  = pkt_beat & eop;
  assign stall_cyc = pkt_open & valid & ~ready;

  always_comb begin
    st_d = st_q;
    if (eop_beat) begin
      st_d = PS_IDLE;
    end else if (sop_beat) begin
      st_d = PS_OPEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  pfm_sat_cnt #(.W(LEN_W), .RST_VAL('0)) u_len_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sop_beat),
    .load_val (LEN_ONE),
    .inc      (pkt_beat & pkt_open),
    .q        (len_q)
  );

  pfm_sat_cnt #(.W(STALL_W), .RST_VAL('0)) u_stall_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sop_beat),
    .load_val (STALL_Z),
    .inc      (stall_cyc),
    .q        (stall_q)
  );

  always_comb begin
    if (sop_beat) begin
      fin_len   = LEN_ONE;
      fin_stall = STALL_Z;
    end else begin
      fin_len   = (len_q == LEN_MAX) ? LEN_MAX : (len_q + 1'b1);
      fin_stall = stall_q;
    end
  end

  // R2: an open packet stays open until a beat is accepted
  a_r2_stay_open: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_open && !(valid && ready)) |=> pkt_open);

  // R3: an open packet has counted at least its opening beat
  a_r3_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_open |-> (len_q != '0));

  // R4: the not-ready count moves only on valid-high, ready-low cycles
  a_r4_stall_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_open && !(valid && !ready)) |=> $stable(stall_q));

endmodule

// File: rtl/pfm_gap_timer.sv
module pfm_gap_timer
  import pfm_pkg::*;
#(
  parameter int GAP_W = PFM_GAP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop_beat,
  input  logic             eop_beat,
  output logic [GAP_W-1:0] gap_out
);

  localparam logic [GAP_W-1:0] GAP_MAX = '1;
  localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] hold_q, hold_d;
  logic             hold_en;

  pfm_sat_cnt #(.W(GAP_W), .RST_VAL(GAP_MAX)) u_gap_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (eop_beat),
    .load_val (GAP_ONE),
    .inc      (1'b1),
    .q        (cnt_q)
  );

  always_comb begin
    hold_en = sop_beat;
    hold_d  = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= GAP_MAX;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  assign gap_out = sop_beat ? cnt_q : hold_q;

  // R5: a close restarts the interval at one
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    eop_beat |=> (cnt_q == GAP_ONE));

  // R5: the interval timer never reads zero
  a_r5_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '0);

endmodule

// File: rtl/pkt_flow_monitor.sv
module pkt_flow_monitor
  import pfm_pkg::*;
#(
  parameter int LEN_W   = PFM_LEN_W_DEF,
  parameter int STALL_W = PFM_STALL_W_DEF,
  parameter int GAP_W   = PFM_GAP_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mon_valid,
  input  logic               mon_ready,
  input  logic               mon_sop,
  input  logic               mon_eop,
  input  logic [LEN_W-1:0]   cfg_expect_len,
  output logic               rpt_strobe,
  output logic [LEN_W-1:0]   rpt_len,
  output logic [STALL_W-1:0] rpt_stall,
  output logic [GAP_W-1:0]   rpt_gap,
  output logic               rpt_short
);

  logic               sop_beat;
  logic               eop_beat;
  logic [LEN_W-1:0]   fin_len;
  logic [STALL_W-1:0] fin_stall;
  logic [GAP_W-1:0]   fin_gap;

  logic               rec_en;
  logic [LEN_W-1:0]   len_d;
  logic [STALL_W-1:0] stall_d;
  logic [GAP_W-1:0]   gap_d;
  logic               short_d;

  pfm_pkt_tracker #(.LEN_W(LEN_W), .STALL_W(STALL_W)) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (mon_valid),
    .ready     (mon_ready),
    .sop       (mon_sop),
    .eop       (mon_eop),
    .sop_beat  (sop_beat),
    .eop_beat  (eop_beat),
    .fin_len   (fin_len),
    .fin_stall (fin_stall)
  );

  pfm_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .sop_beat (sop_beat),
    .eop_beat (eop_beat),
    .gap_out  (fin_gap)
  );

  always_comb begin
    rec_en  = eop_beat;
    len_d   = fin_len;
    stall_d = fin_stall;
    gap_d   = fin_gap;
    short_d = (fin_len < cfg_expect_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_strobe <= 1'b0;
    end else begin
      rpt_strobe <= rec_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_len   <= '0;
      rpt_stall <= '0;
      rpt_gap   <= '0;
      rpt_short <= 1'b0;
    end else if (rec_en) begin
      rpt_len   <= len_d;
      rpt_stall <= stall_d;
      rpt_gap   <= gap_d;
      rpt_short <= short_d;
    end
  end

  // R7: a record appears only in the cycle after an accepted end-of-packet beat
  a_r7_strobe_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_strobe |-> $past(mon_valid && mon_ready && mon_eop));

  // R7: report fields hold when no packet closes
  a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eop_beat |=> ($stable(rpt_len) && $stable(rpt_stall) && $stable(rpt_gap)));

  // R6: short flag agrees with the length and the expected length of the closing cycle
  a_r6_short_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_strobe |-> (rpt_short == (rpt_len < $past(cfg_expect_len))));

  // R3: every record reports at least one beat
  a_r3_len_positive: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_strobe |-> (rpt_len != '0));

endmodule

// File: tb/pkt_flow_monitor_bench.sv
`timescale 1ns/1ps
module pkt_flow_monitor_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mon_valid, mon_ready, mon_sop, mon_eop;
  logic [7:0] cfg_expect_len;
  logic       rpt_strobe;
  logic [7:0] rpt_len;
  logic [7:0] rpt_stall;
  logic [9:0] rpt_gap;
  logic       rpt_short;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pkt_flow_monitor u_pkt_flow_monitor (
    .clk            (clk),
    .rst_n          (rst_n),
    .mon_valid      (mon_valid),
    .mon_ready      (mon_ready),
    .mon_sop        (mon_sop),
    .mon_eop        (mon_eop),
    .cfg_expect_len (cfg_expect_len),
    .rpt_strobe     (rpt_strobe),
    .rpt_len        (rpt_len),
    .rpt_stall      (rpt_stall),
    .rpt_gap        (rpt_gap),
    .rpt_short      (rpt_short)
  );

  // beats, not-ready cycles before beat 2, idle cycles before open, expected gap
  localparam int VEC [6][4] = '{
    '{1,  0, 0, 1023},
    '{4,  0, 0, 2},
    '{6,  3, 2, 4},
    '{3,  5, 1, 3},
    '{10, 0, 7, 9},
    '{2,  1, 0, 2}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic r, input logic s, input logic e);
    @(negedge clk);
    mon_valid = v; mon_ready = r; mon_sop = s; mon_eop = e;
  endtask

  task automatic send_pkt(input int beats, input int stalls, input int idle);
    for (int k = 0; k < idle; k++) cyc(0, 0, 0, 0);
    for (int i = 0; i < beats; i++) begin
      if (i == 1) for (int k = 0; k < stalls; k++) cyc(1, 0, 0, 0);
      cyc(1, 1, (i == 0), (i == beats - 1));
    end
    @(negedge clk);
    mon_valid = 0; mon_ready = 0; mon_sop = 0; mon_eop = 0;
  endtask

  task automatic expect_rec(input string req, input int len, input int stall,
                            input int gap, input int shrt);
    chk({req, " strobe"}, int'(rpt_strobe), 1);
    chk({req, " len"},    int'(rpt_len), len);
    chk({req, " stall"},  int'(rpt_stall), stall);
    chk({req, " gap"},    int'(rpt_gap), gap);
    chk({req, " short"},  int'(rpt_short), shrt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mon_valid = 0; mon_ready = 0; mon_sop = 0; mon_eop = 0;
    cfg_expect_len = 8'd4;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 strobe", int'(rpt_strobe), 0);
    chk("R1 len", int'(rpt_len), 0);
    chk("R1 gap", int'(rpt_gap), 0);

    // table: R3 R4 R5 R6 R9
    for (int n = 0; n < 6; n++) begin
      send_pkt(VEC[n][0], VEC[n][1], VEC[n][2]);
      expect_rec("R3/R4/R5 table", VEC[n][0], VEC[n][1], VEC[n][3],
                 (VEC[n][0] < 4) ? 1 : 0);
    end

    // R2: accepted beats outside a packet are ignored, even with eop set
    for (int k = 0; k < 3; k++) begin
      cyc(1, 1, 0, 1);
      chk("R2 no strobe", int'(rpt_strobe), 0);
    end
    // R4: not-ready cycles before the opening beat are not counted
    for (int k = 0; k < 4; k++) cyc(1, 0, 1, 0);
    chk("R2 no strobe", int'(rpt_strobe), 0);
    cyc(1, 1, 1, 0); cyc(1, 1, 0, 0); cyc(1, 1, 0, 1);
    @(negedge clk); mon_valid = 0; mon_ready = 0; mon_sop = 0; mon_eop = 0;
    expect_rec("R2/R4 pre-open", 3, 0, 9, 1);

    // R7: fields hold, strobe one cycle only
    cyc(0, 0, 0, 0);
    chk("R7 strobe low", int'(rpt_strobe), 0);
    chk("R7 len held", int'(rpt_len), 3);
    cyc(0, 0, 0, 0);
    chk("R7 gap held", int'(rpt_gap), 9);

    // R10: second sop inside an open packet is a data beat
    cyc(1, 1, 1, 0); cyc(1, 1, 1, 0); cyc(1, 1, 0, 0); cyc(1, 1, 0, 1);
    @(negedge clk); mon_valid = 0; mon_ready = 0; mon_sop = 0; mon_eop = 0;
    expect_rec("R10 mid sop", 4, 0, 4, 0);

    // R9/R5/R7: two-beat packet immediately followed by a single-beat packet
    cyc(1, 1, 1, 0); cyc(1, 1, 0, 1);
    @(negedge clk);
    expect_rec("R7 back-to-back first", 2, 0, 2, 1);
    mon_valid = 1; mon_ready = 1; mon_sop = 1; mon_eop = 1;
    @(negedge clk);
    expect_rec("R9 single beat", 1, 0, 1, 1);
    mon_valid = 0; mon_ready = 0; mon_sop = 0; mon_eop = 0;

    // R6: boundary around the expected length
    cfg_expect_len = 8'd12;
    send_pkt(10, 0, 0);
    expect_rec("R6 below", 10, 0, 2, 1);
    send_pkt(12, 0, 0);
    expect_rec("R6 equal", 12, 0, 2, 0);
    cfg_expect_len = 8'd4;

    // R8: all three counts saturate
    send_pkt(300, 300, 1100);
    expect_rec("R8 saturate", 255, 255, 1023, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule